// File: doc/BRIEF.md
# Duty-Cycle Clock Throttle Controller

This block throttles one core by holding its clock off for a programmable share of a fixed-length window. Software writes a single control word through a plain write port. The word holds an enable bit, a granularity selector and a 4-bit duty level. The block drives an active-high clock enable into a separate glitch-free gating cell. It also drives a status flag that is high for every cycle of a stop phase.

Each window is `WINDOW_CYCLES` reference cycles long, and its length does not depend on the level. The stop phase fills the first part of the window and the run phase fills the remainder. A level written in the middle of a window takes effect only when the next window starts. After software enables the block, the first window starts once a fixed arming delay has passed. After software disables it, a stop phase that is already running is cut off within a bounded number of cycles. Every instance keeps its own window counter, and instances are not aligned with one another.

The write port has no handshake. A word is captured on any clock edge where `wr_valid` is high.

Top module: `duty_throttle_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the control word and all counters. During and after reset `clk_en` is high and `stop_active` is low, and no stop phase occurs until a new enabling write arrives.
- R2: `clk_en` is low in exactly those cycles in which `stop_active` is high.
- R3: A write with `wr_valid` high captures `wr_data[3:0]` as the level, `wr_data[4]` as coarse mode and `wr_data[5]` as enable. In fine mode (bit 4 = 0), each window begins with a stop phase of level*WINDOW_CYCLES/16 cycles.
- R4: Consecutive stop phases start exactly WINDOW_CYCLES cycles apart, whatever the level.
- R5: In fine mode, level 15 gives the same stop length as level 14.
- R6: In coarse mode, only `wr_data[2:0]` counts, in eighths of the window, and bit 3 is ignored. Coarse level 7 saturates to coarse level 6.
- R7: When the block is disabled, or enabled with an effective level of zero, no stop cycle occurs.
- R8: After an enabling write is captured on a clock edge, the first stop cycle begins ACT_DELAY+1 cycles after that edge.
- R9: After a disabling write is captured, `stop_active` stays high for at most REL_DELAY+1 further cycles. This is exactly REL_DELAY+1 when the stop phase would otherwise have run longer. If the write lands in a run phase, no further stop cycle occurs.
- R10: A level written during a window leaves that window's stop length unchanged. The new level applies from the next window onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Capture `wr_data` on this edge |
| wr_data | input | 6 | [5] enable, [4] coarse mode, [3:0] level |
| clk_en | output | 1 | Active-high enable for the core clock gate |
| stop_active | output | 1 | High while a stop phase is in progress |

## Verification
The bench builds the block with WINDOW_CYCLES=64, ACT_DELAY=5 and REL_DELAY=3. With a 64-cycle window, every fine step is exactly 4 stop cycles, so each level, the top-level saturation and both coarse settings map to a whole expected count. The short window also lets the bench see several windows per setting. The small release delay lets the bench start a disable right at the beginning of a 56-cycle stop phase and see the stop phase cut off at exactly four cycles.

// File: rtl/thr_pkg.sv
package thr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_WIN,
    ST_REL
  } thr_state_e;

  typedef struct packed {
    logic       en;
    logic       coarse;
    logic [3:0] lvl;
  } thr_cfg_t;

  localparam int CFG_W = $bits(thr_cfg_t);

  // Effective level in sixteenths, with the top step of each mode saturated
  function automatic logic [3:0] eff_sixteenths(input logic coarse, input logic [3:0] lvl);
    logic [2:0] c8;
    if (coarse) begin
      c8 = (lvl[2:0] == 3'd7) ? 3'd6 : lvl[2:0];
      return {c8, 1'b0};
    end
    return (lvl == 4'd15) ? 4'd14 : lvl;
  endfunction

endpackage

// File: rtl/thr_cfg_reg.sv
module thr_cfg_reg
  import thr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [CFG_W-1:0] wr_data,
  output thr_cfg_t         cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n)        cfg <= '0;
    else if (wr_valid) cfg <= thr_cfg_t'(wr_data);
  end

endmodule

// File: rtl/thr_duty_calc.sv
module thr_duty_calc
  import thr_pkg::*;
#(
  parameter int WINDOW_CYCLES = 64,
  parameter int LEN_W         = $clog2(WINDOW_CYCLES + 1)
) (
  input  logic             coarse,
  input  logic [3:0]       lvl,
  output logic [LEN_W-1:0] stop_len
);

  localparam int PW = LEN_W + 4;

  logic [3:0] eff;

  always_comb begin
    eff      = eff_sixteenths(coarse, lvl);
    stop_len = LEN_W'((PW'(eff) * PW'(WINDOW_CYCLES)) >> 4);
  end

endmodule

// File: rtl/thr_window_fsm.sv
module thr_window_fsm
  import thr_pkg::*;
#(
  parameter int WINDOW_CYCLES = 64,
  parameter int ACT_DELAY     = 5,
  parameter int REL_DELAY     = 3,
  parameter int LEN_W         = $clog2(WINDOW_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LEN_W-1:0] next_len,
  output logic             stop
);

  localparam int DLY_W   = (ACT_DELAY > 1) ? $clog2(ACT_DELAY + 1) : 1;
  localparam int REL_W   = $clog2(REL_DELAY + 2);
  localparam int AGE_W   = $clog2(REL_DELAY + 3);
  localparam int MAX_LEN = (14 * WINDOW_CYCLES) / 16;

  thr_state_e       st;
  logic [LEN_W-1:0] win;
  logic [LEN_W-1:0] cur_len;
  logic [DLY_W-1:0] dly;
  logic [REL_W-1:0] rel;

  assign stop = ((st == ST_WIN) || (st == ST_REL)) && (win < cur_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      win     <= '0;
      cur_len <= '0;
      dly     <= '0;
      rel     <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (en) begin
            st  <= ST_ARM;
            dly <= '0;
          end
        end
        ST_ARM: begin
          if (!en) st <= ST_IDLE;
          else if (dly == DLY_W'(ACT_DELAY - 1)) begin
            st      <= ST_WIN;
            win     <= '0;
            cur_len <= next_len;
          end else dly <= dly + 1'b1;
        end
        ST_WIN: begin
          if (!en) begin
            if (stop && (REL_DELAY != 0)) begin
              st  <= ST_REL;
              rel <= '0;
              win <= win + 1'b1;
            end else st <= ST_IDLE;
          end else if (win == LEN_W'(WINDOW_CYCLES - 1)) begin
            win     <= '0;
            cur_len <= next_len;
          end else win <= win + 1'b1;
        end
        default: begin
          if (((win + 1'b1) >= cur_len) || (rel == REL_W'(REL_DELAY - 1))) st <= ST_IDLE;
          else begin
            rel <= rel + 1'b1;
            win <= win + 1'b1;
          end
        end
      endcase
    end
  end

  // Cycles of stop seen since the enable dropped, for the release bound
  logic [AGE_W-1:0] rel_age;
  always_ff @(posedge clk) begin
    if (!rst_n || en || !stop) rel_age <= '0;
    else if (rel_age != {AGE_W{1'b1}}) rel_age <= rel_age + 1'b1;
  end

  // R8
  act_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WIN && $past(st) == ST_ARM) |-> $past(dly) == DLY_W'(ACT_DELAY - 1));

  // R5
  len_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_len <= LEN_W'(MAX_LEN));

  // R10
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WIN && $past(st) == ST_WIN && win != '0) |-> $stable(cur_len));

  // R9
  rel_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_age <= AGE_W'(REL_DELAY + 1));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_IDLE) |-> !stop);

endmodule

// File: rtl/duty_throttle_ctrl.sv
module duty_throttle_ctrl
  import thr_pkg::*;
#(
  parameter int WINDOW_CYCLES = 64,
  parameter int ACT_DELAY     = 5,
  parameter int REL_DELAY     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [5:0] wr_data,
  output logic       clk_en,
  output logic       stop_active
);

  localparam int LEN_W = $clog2(WINDOW_CYCLES + 1);

  thr_cfg_t         cfg;
  logic [LEN_W-1:0] stop_len;
  logic             stop;

  thr_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .cfg      (cfg)
  );

  thr_duty_calc #(.WINDOW_CYCLES(WINDOW_CYCLES), .LEN_W(LEN_W)) u_calc (
    .coarse   (cfg.coarse),
    .lvl      (cfg.lvl),
    .stop_len (stop_len)
  );

  thr_window_fsm #(
    .WINDOW_CYCLES (WINDOW_CYCLES),
    .ACT_DELAY     (ACT_DELAY),
    .REL_DELAY     (REL_DELAY),
    .LEN_W         (LEN_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg.en),
    .next_len (stop_len),
    .stop     (stop)
  );

  assign clk_en      = !stop;
  assign stop_active = stop;

  // R1
  reset_open_chk: assert property (@(posedge clk) !rst_n |=> (clk_en && !stop_active));

endmodule

// File: tb/duty_throttle_ctrl_tb.sv
`timescale 1ns/1ps
module duty_throttle_ctrl_tb;

  localparam int WIN = 64;
  localparam int ACT = 5;
  localparam int REL = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [5:0] wr_data = '0;
  logic       clk_en;
  logic       stop_active;

  int checks = 0;
  int errors = 0;
  int mism   = 0;
  int cyc    = 0;
  int run    = 0;
  bit prev   = 1'b0;
  bit done   = 1'b0;
  int len_q[$];
  int rise_q[$];

  always #2.5 clk = ~clk;

  duty_throttle_ctrl #(.WINDOW_CYCLES(WIN), .ACT_DELAY(ACT), .REL_DELAY(REL)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .clk_en      (clk_en),
    .stop_active (stop_active)
  );

  // Monitor: records stop-phase lengths and start cycles into queues
  always @(negedge clk) begin
    cyc++;
    if (rst_n && (clk_en !== !stop_active)) mism++;
    if (stop_active) run++;
    if (stop_active && !prev) rise_q.push_back(cyc);
    if (!stop_active && prev) len_q.push_back(run);
    if (!stop_active) run = 0;
    prev = stop_active;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit en, input bit coarse, input logic [3:0] lvl);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = {en, coarse, lvl};
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_stop(input bit lvl);
    int g = 0;
    while (stop_active !== lvl && g < 1000) begin
      @(negedge clk);
      g++;
    end
  endtask

  // Expected stop length compared against every completed stop phase
  task automatic measure(input int exp_len, input string req);
    repeat (140) @(negedge clk);
    len_q.delete();
    rise_q.delete();
    repeat (140) @(negedge clk);
    if (exp_len == 0) begin
      chk(len_q.size() == 0 && rise_q.size() == 0, req, len_q.size() + rise_q.size(), 0);
    end else begin
      chk(len_q.size() >= 2, req, len_q.size(), 2);
      foreach (len_q[i]) chk(len_q[i] == exp_len, req, len_q[i], exp_len);
      for (int i = 1; i < rise_q.size(); i++)
        chk(rise_q[i] - rise_q[i-1] == WIN, "R4", rise_q[i] - rise_q[i-1], WIN);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(clk_en == 1'b1, "R1", clk_en, 1);
    chk(stop_active == 1'b0, "R1", stop_active, 0);
    rst_n = 1'b1;
    measure(0, "R1");

    // R8 arming delay
    begin
      int n;
      wr(1'b1, 1'b0, 4'd4);
      n = 1;
      while (!stop_active && n < 200) begin
        @(negedge clk);
        n++;
      end
      chk(n == ACT + 2, "R8", n, ACT + 2);
    end
    measure(16, "R3");
    wr(1'b1, 1'b0, 4'd8);
    measure(32, "R3");
    wr(1'b1, 1'b0, 4'd15);
    measure(56, "R5");
    wr(1'b1, 1'b0, 4'd14);
    measure(56, "R5");
    wr(1'b1, 1'b1, 4'd7);
    measure(48, "R6");
    wr(1'b1, 1'b1, 4'hB);
    measure(24, "R6");
    wr(1'b1, 1'b0, 4'd0);
    measure(0, "R7");

    // R10 mid-window change
    wr(1'b1, 1'b0, 4'd4);
    repeat (140) @(negedge clk);
    wait_stop(1'b1);
    len_q.delete();
    wr(1'b1, 1'b0, 4'd8);
    repeat (140) @(negedge clk);
    chk(len_q.size() >= 2, "R10", len_q.size(), 2);
    if (len_q.size() >= 2) begin
      chk(len_q[0] == 16, "R10", len_q[0], 16);
      chk(len_q[1] == 32, "R10", len_q[1], 32);
    end

    // R9 disable at the start of a long stop phase
    wr(1'b1, 1'b0, 4'd15);
    repeat (140) @(negedge clk);
    wait_stop(1'b0);
    wait_stop(1'b1);
    wr(1'b0, 1'b0, 4'd15);
    begin
      int cnt = 0;
      for (int i = 0; i < 20; i++) begin
        if (stop_active) cnt++;
        @(negedge clk);
      end
      chk(cnt == REL + 1, "R9", cnt, REL + 1);
    end
    measure(0, "R7");

    // R9 disable during a run phase
    wr(1'b1, 1'b0, 4'd4);
    wait_stop(1'b1);
    wait_stop(1'b0);
    wr(1'b0, 1'b0, 4'd4);
    begin
      int cnt = 0;
      for (int i = 0; i < 200; i++) begin
        if (stop_active) cnt++;
        @(negedge clk);
      end
      chk(cnt == 0, "R9", cnt, 0);
    end

    // R1 reset in the middle of a stop phase
    wr(1'b1, 1'b0, 4'd15);
    wait_stop(1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(clk_en == 1'b1, "R1", clk_en, 1);
    chk(stop_active == 1'b0, "R1", stop_active, 0);
    rst_n = 1'b1;
    measure(0, "R1");

    chk(mism == 0, "R2", mism, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule